// File: doc/BRIEF.md
# Interrupt-Capable 32-Pin General-Purpose I/O Port

This block is a 32-pin I/O port on a simple single-cycle register bus. Software sets an output value and a direction for each pin and reads back the pin levels after a two-flop synchroniser. Every pin can also raise an interrupt. Each pin has a 2-bit trigger code that selects low level, high level, rising edge or falling edge. A separate per-pin bit makes the pin fire on both edges, and this bit overrides the code.

Detected events set sticky status bits. Software clears a status bit by writing 1 to it. A mask register decides which status bits reach the interrupt lines. Pins 0 to 15 drive one line, pins 16 to 31 drive a second line, and a third line combines all 32 pins. Pad drivers, pin multiplexing and any bus bridge sit outside the block.

Top module: `gpio_irq_port`

## Requirements
- R1: Registers sit at byte offsets 0x00 output data, 0x04 direction, 0x08 pad level (read-only), 0x0C trigger codes for pins 0-15, 0x10 trigger codes for pins 16-31, 0x14 mask, 0x18 status, 0x1C both-edge select. A write to one of these offsets takes effect on the clock edge. Reads are combinational. Reset clears every register to zero.
- R2: `pad_oe` equals the direction register (1 = output) and `pad_out` equals the output data register.
- R3: The pad level register returns each pin's input after two clock edges of synchronisation, for input and output pins alike. A status bit set by a pad edge becomes visible on the third rising clock edge after the pad changes.
- R4: Pin n takes its trigger code from bits [2*(n mod 16)+1 : 2*(n mod 16)] of the low or high code register. The codes are 0 = level low, 1 = level high, 2 = rising edge, 3 = falling edge. Edges are found by comparing the current synchronised sample with the previous one.
- R5: When a pin's bit in the both-edge select register is 1, that pin sets status on every rising edge and every falling edge, and its trigger code has no effect.
- R6: Writing 1 to a status bit clears it. Writing 0 leaves the bit unchanged. Writing all ones clears every bit that has no active condition.
- R7: A pin in level mode sets its status bit on every cycle that its level is active. A clear in the same cycle as an active condition leaves the bit set.
- R8: An interrupt line is asserted only by bits that are set in both the status register and the mask register. A mask bit of 1 enables its pin.
- R9: `irq_lo` covers pins 0-15 and `irq_hi` covers pins 16-31. `irq_all` is asserted when either of them is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Output value per pin |
| pad_oe | output | 32 | Output enable per pin |
| irq_lo | output | 1 | Interrupt for pins 0-15 |
| irq_hi | output | 1 | Interrupt for pins 16-31 |
| irq_all | output | 1 | Interrupt for all pins |

## Verification
The critical overlap is a status set from a pad event and a software clear landing on the same clock edge. The bench raises a pad and waits for the two synchroniser edges. It then issues an all-ones status write so that the write and the edge detection share the third edge. It expects the bit to survive while every other bit clears. Separately, a level-active pin is cleared while its level is still asserted, and the bench expects its status to read 1 right after the clear.

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
  parameter int PINS = 32,
  parameter int AW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [PINS-1:0] bus_wdata,
  output logic [PINS-1:0] bus_rdata,
  input  logic [PINS-1:0] pad_in,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pad_oe,
  output logic            irq_lo,
  output logic            irq_hi,
  output logic            irq_all
);
  localparam int HALF = PINS / 2;

  localparam logic [AW-1:0] A_DATA = AW'(5'h00);
  localparam logic [AW-1:0] A_DIR  = AW'(5'h04);
  localparam logic [AW-1:0] A_PAD  = AW'(5'h08);
  localparam logic [AW-1:0] A_CLO  = AW'(5'h0C);
  localparam logic [AW-1:0] A_CHI  = AW'(5'h10);
  localparam logic [AW-1:0] A_MASK = AW'(5'h14);
  localparam logic [AW-1:0] A_STAT = AW'(5'h18);
  localparam logic [AW-1:0] A_BOTH = AW'(5'h1C);

  logic [PINS-1:0] data_q, dir_q, cfg_lo_q, cfg_hi_q, mask_q, stat_q, both_q;
  logic [PINS-1:0] sync1_q, sync2_q, prev_q;
  logic [PINS-1:0] hit, clr;

  wire [PINS-1:0] rise = sync2_q & ~prev_q;
  wire [PINS-1:0] fall = ~sync2_q & prev_q;

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    localparam int F = 2 * (i % HALF);
    logic [1:0] code;
    if (i < HALF) begin : g_lo
      assign code = cfg_lo_q[F+1:F];
    end else begin : g_hi
      assign code = cfg_hi_q[F+1:F];
    end
    always_comb begin
      if (both_q[i]) hit[i] = rise[i] | fall[i];
      else begin
        case (code)
          2'd0:    hit[i] = ~sync2_q[i];
          2'd1:    hit[i] = sync2_q[i];
          2'd2:    hit[i] = rise[i];
          default: hit[i] = fall[i];
        endcase
      end
    end
  end

  assign clr = (bus_we && bus_addr == A_STAT) ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      dir_q    <= '0;
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
      mask_q   <= '0;
      stat_q   <= '0;
      both_q   <= '0;
      sync1_q  <= '0;
      sync2_q  <= '0;
      prev_q   <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      stat_q  <= (stat_q & ~clr) | hit;
      if (bus_we) begin
        case (bus_addr)
          A_DATA:  data_q   <= bus_wdata;
          A_DIR:   dir_q    <= bus_wdata;
          A_CLO:   cfg_lo_q <= bus_wdata;
          A_CHI:   cfg_hi_q <= bus_wdata;
          A_MASK:  mask_q   <= bus_wdata;
          A_BOTH:  both_q   <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_DATA:  bus_rdata = data_q;
      A_DIR:   bus_rdata = dir_q;
      A_PAD:   bus_rdata = sync2_q;
      A_CLO:   bus_rdata = cfg_lo_q;
      A_CHI:   bus_rdata = cfg_hi_q;
      A_MASK:  bus_rdata = mask_q;
      A_STAT:  bus_rdata = stat_q;
      A_BOTH:  bus_rdata = both_q;
      default: bus_rdata = '0;
    endcase
  end

  wire [PINS-1:0] pend = stat_q & mask_q;

  assign pad_out = data_q;
  assign pad_oe  = dir_q;
  assign irq_lo  = |pend[HALF-1:0];
  assign irq_hi  = |pend[PINS-1:HALF];
  assign irq_all = |pend;
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
  parameter int PINS = 32,
  parameter int AW   = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_we,
  input logic [AW-1:0]   bus_addr,
  input logic [PINS-1:0] bus_wdata,
  input logic [PINS-1:0] pad_in,
  input logic [PINS-1:0] pad_oe,
  input logic            irq_lo,
  input logic            irq_hi,
  input logic            irq_all,
  input logic [PINS-1:0] stat_q,
  input logic [PINS-1:0] mask_q,
  input logic [PINS-1:0] sync2_q
);
  logic [PINS-1:0] clr_v;
  assign clr_v = (bus_we && bus_addr == AW'(5'h18)) ? bus_wdata : '0;

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(stat_q) & ~$past(clr_v) & ~stat_q) == '0)); // R6

  AST_OE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(5'h04)) |=> (pad_oe == $past(bus_wdata))); // R2

  AST_PAD_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rst_n, 2)) |-> (sync2_q == $past(pad_in, 2))); // R3

  AST_MASK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_all); // R8

  AST_IRQ_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    irq_all == (irq_lo || irq_hi)); // R9
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.PINS(PINS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pad_in(pad_in), .pad_oe(pad_oe),
  .irq_lo(irq_lo), .irq_hi(irq_hi), .irq_all(irq_all),
  .stat_q(stat_q), .mask_q(mask_q), .sync2_q(sync2_q)
);

// File: tb/gpio_irq_port_tb.sv
module gpio_irq_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  logic        irq_lo, irq_hi, irq_all;

  int checks = 0;
  int errors = 0;
  logic [31:0] sh_lo = '0, sh_hi = '0, sh_both = '0, r;

  always #5 clk = ~clk;

  gpio_irq_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq_lo(irq_lo), .irq_hi(irq_hi),
    .irq_all(irq_all)
  );

  // pin[11:7] both[6] code[5:4] from[3] to[2] pre[1] post[0]
  localparam logic [11:0] VEC [9] = '{
    {5'd3,  1'b0, 2'd2, 1'b0, 1'b1, 1'b0, 1'b1},
    {5'd3,  1'b0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0},
    {5'd20, 1'b0, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1},
    {5'd20, 1'b0, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0},
    {5'd7,  1'b0, 2'd1, 1'b0, 1'b1, 1'b0, 1'b1},
    {5'd7,  1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1},
    {5'd30, 1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1},
    {5'd30, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1},
    {5'd16, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 pad_oe reset", pad_oe, 32'h0);
    chk("R2 pad_out reset", pad_out, 32'h0);
    chk("R8 irq reset", {29'd0, irq_lo, irq_hi, irq_all}, 32'h0);
    rd(5'h04, r); chk("R1 dir reset", r, 32'h0);
    rd(5'h14, r); chk("R1 mask reset", r, 32'h0);
    rd(5'h0C, r); chk("R1 cfg lo reset", r, 32'h0);
    rd(5'h1C, r); chk("R1 both reset", r, 32'h0);
    wait_n(1);

    // R2 direction and data
    wr(5'h00, 32'h1234_5678);
    wr(5'h04, 32'hFFFF_0000);
    chk("R2 pad_out", pad_out, 32'h1234_5678);
    chk("R2 pad_oe", pad_oe, 32'hFFFF_0000);
    rd(5'h00, r); chk("R1 data readback", r, 32'h1234_5678);

    // R3 synchroniser latency, independent of direction
    pad_in = 32'h0F0F_00F0;
    wait_n(1);
    rd(5'h08, r); chk("R3 pad after 1 edge", r, 32'h0);
    wait_n(1);
    rd(5'h08, r); chk("R3 pad after 2 edges", r, 32'h0F0F_00F0);
    pad_in = '0;
    wait_n(4);

    // table of trigger vectors: R4, R5
    for (int v = 0; v < 9; v++) begin
      automatic logic [4:0] pin = VEC[v][11:7];
      automatic logic [1:0] code = VEC[v][5:4];
      automatic string tag = VEC[v][6] ? "R5" : "R4";
      if (pin < 16) begin
        sh_lo[2*pin +: 2] = code; wr(5'h0C, sh_lo);
      end else begin
        sh_hi[2*(pin-16) +: 2] = code; wr(5'h10, sh_hi);
      end
      sh_both[pin] = VEC[v][6];
      wr(5'h1C, sh_both);
      pad_in[pin] = VEC[v][3];
      wait_n(4);
      wr(5'h18, 32'h1 << pin);
      rd(5'h18, r); chk({tag, " before change"}, {31'd0, r[pin]}, {31'd0, VEC[v][1]});
      pad_in[pin] = VEC[v][2];
      wait_n(4);
      rd(5'h18, r); chk({tag, " after change"}, {31'd0, r[pin]}, {31'd0, VEC[v][0]});
    end

    // routing, masking and clear semantics
    pad_in = '0;
    wr(5'h0C, 32'hAAAA_AAAA);
    wr(5'h10, 32'hAAAA_AAAA);
    wr(5'h1C, 32'h0);
    wait_n(4);
    wr(5'h18, 32'hFFFF_FFFF);
    rd(5'h18, r); chk("R6 clear all", r, 32'h0);
    pad_in = 32'h0020_0020;
    wait_n(2);
    rd(5'h18, r); chk("R3 status not yet set", r, 32'h0);
    wait_n(1);
    rd(5'h18, r); chk("R3 status set on third edge", r, 32'h0020_0020);
    chk("R8 masked irq", {31'd0, irq_all}, 32'h0);
    wr(5'h14, 32'h0000_0020);
    chk("R9 low line", {29'd0, irq_lo, irq_hi, irq_all}, 32'h5);
    wr(5'h14, 32'h0020_0000);
    chk("R9 high line", {29'd0, irq_lo, irq_hi, irq_all}, 32'h3);
    wr(5'h18, 32'h0);
    rd(5'h18, r); chk("R6 write zero", r, 32'h0020_0020);
    wr(5'h18, 32'h0000_0020);
    rd(5'h18, r); chk("R6 single clear", r, 32'h0020_0000);
    chk("R8 high still pending", {31'd0, irq_hi}, 32'h1);
    wr(5'h18, 32'hFFFF_FFFF);
    chk("R8 irq after clear", {31'd0, irq_all}, 32'h0);

    // R7 set and clear on the same edge
    wr(5'h14, 32'h0);
    pad_in[9] = 1'b1;
    wait_n(2);
    wr(5'h18, 32'hFFFF_FFFF);
    rd(5'h18, r); chk("R7 set wins over clear", r, 32'h0000_0200);
    wr(5'h18, 32'hFFFF_FFFF);
    rd(5'h18, r); chk("R6 later clear", r, 32'h0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule